// File: doc/BRIEF.md
# Linked-Descriptor DMA Engine

This block is a single-channel DMA engine that moves 32-bit words between memory and peripheral register addresses under the control of descriptors held in memory. Software writes the address of the first descriptor and sets a start bit. The engine then reads the descriptor, copies the requested number of bytes one word at a time, and follows the descriptor's link to the next one. A link of zero ends the run. A link that points back to an earlier descriptor forms a ring that never ends on its own.

A descriptor is eight words at a 32-byte aligned address. Word 0 holds the flags, word 1 the source address, word 2 the destination address, word 3 the byte count, word 4 the stride (not used here), word 5 the link, and words 6 and 7 are unused. A flag can pace the transfer, so that every word waits for one chosen peripheral request input. Each descriptor that is loaded copies from its own source and destination addresses. Address progress from an earlier pass is never carried over.

The memory side is a word-wide master. It holds its request until the acknowledge arrives, and read data is taken on the acknowledge. The control side is a small register port with a combinational read path.

Top module: `dmac_chain_engine`

## Requirements
- R1: After reset the engine is idle, the status register (offset 0) reads zero and no memory request is raised.
- R2: A start (write of bit 0 at offset 0 while idle) loads the descriptor at the address written at offset 1, with its low 5 bits forced to zero. The engine reads descriptor words 0 to 5 at byte offsets 0, 4, 8, 12, 16 and 20, in that order.
- R3: Flag bit 8 makes the source address advance by 4 after each word, and flag bit 4 does the same for the destination address. A clear bit keeps that address fixed for the whole descriptor.
- R4: Each word moved is one read from the source followed by one write of that same data to the destination. A byte count of N moves N/4 words, so a count of 4 gives exactly one write.
- R5: When a descriptor completes, the engine loads the descriptor at the link address, with its low 5 bits ignored. A zero link returns the engine to idle and sets the end-of-chain bit (bit 2 at offset 0).
- R6: Every descriptor that is loaded, including one revisited in a ring, restarts from its own source and destination addresses.
- R7: When flag bit 6 is set, each word waits for the request input chosen by flag bits 20:16. While that request is low, no memory access is made and waiting bit 1 at offset 0 reads 1. While the request stays high, words and descriptors proceed without pause.
- R8: Writing bit 1 at offset 0 while active returns the engine to idle at the next word boundary. No further memory writes follow, and the end-of-chain bit stays clear.
- R9: A memory request keeps its address, direction and write data stable until the acknowledge arrives.
- R10: Offset 1 reads the address of the current descriptor and offset 2 reads the remaining byte count. Bit 0 at offset 0 reads 1 while the engine is active.
- R11: A descriptor whose byte count is below 4 moves no data and passes straight to its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory access complete |
| dreq | input | NREQ | Peripheral request lines |

## Verification
The assertions check four things on every cycle. Memory requests stay stable until acknowledged. The engine makes no memory access while idle or while waiting for a paced request. Descriptor reads always use the expected offset inside a 32-byte block. The end-of-chain flag only rises as the engine goes idle. The bench's scenarios are needed for the rest: the data that lands at each destination under every increment combination, the word count for a given length, the chain and ring walking, the restart of addresses when a ring comes back to a descriptor, and the point at which an abort takes effect.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W       = 32;
    localparam int WORD_BYTES   = WORD_W / 8;
    localparam int BLK_ALIGN_W  = 5;
    localparam int LINK_WORD    = 5;
    localparam int FLG_DST_INC  = 4;
    localparam int FLG_PACED    = 6;
    localparam int FLG_SRC_INC  = 8;
    localparam int FLG_SEL_LSB  = 16;
    localparam int SEL_W        = 5;
    localparam logic [WORD_W-1:0] BLK_MASK = ~WORD_W'((1 << BLK_ALIGN_W) - 1);

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BLK  = 2'd1;
    localparam logic [1:0] REG_LEN  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_GATE, ST_READ, ST_WRITE, ST_LINK
    } dmac_st_e;

    typedef struct packed {
        dmac_st_e          st;
        logic [2:0]        widx;
        logic [WORD_W-1:0] blk;
        logic              src_inc;
        logic              dst_inc;
        logic              paced;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] head;
        logic              abort_p;
        logic              done;
    } dmac_regs_t;
endpackage

// File: rtl/dmac_req_sel.sv
module dmac_req_sel #(
    parameter int NREQ  = 32,
    parameter int SEL_W = 5
) (
    input  logic [NREQ-1:0]  dreq_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    logic [NREQ-1:0] match;

    for (genvar g = 0; g < NREQ; g++) begin : g_line
        assign match[g] = dreq_i[g] && (sel_i == SEL_W'(g));
    end

    assign hit_o = |match;
endmodule

// File: rtl/dmac_addr_step.sv
module dmac_addr_step
    import dmac_pkg::*;
(
    input  logic [WORD_W-1:0] addr_i,
    input  logic              inc_i,
    output logic [WORD_W-1:0] addr_o
);
    assign addr_o = inc_i ? addr_i + WORD_W'(WORD_BYTES) : addr_i;
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
    import dmac_pkg::*;
#(
    parameter int NREQ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic [NREQ-1:0]   dreq
);
    dmac_regs_t r_q, r_d;

    logic              req_hit;
    logic [WORD_W-1:0] src_nx, dst_nx;
    logic              ctrl_wr;
    logic              st_active, st_wait, st_done, is_fetch;

    dmac_req_sel #(.NREQ(NREQ), .SEL_W(SEL_W)) u_sel (
        .dreq_i (dreq),
        .sel_i  (r_q.sel),
        .hit_o  (req_hit)
    );

    dmac_addr_step u_src_step (.addr_i(r_q.src), .inc_i(r_q.src_inc), .addr_o(src_nx));
    dmac_addr_step u_dst_step (.addr_i(r_q.dst), .inc_i(r_q.dst_inc), .addr_o(dst_nx));

    assign ctrl_wr   = csr_we && (csr_addr == REG_CTRL);
    assign st_active = (r_q.st != ST_IDLE);
    assign st_wait   = (r_q.st == ST_GATE) && r_q.paced && !req_hit && !r_q.abort_p;
    assign st_done   = r_q.done;
    assign is_fetch  = (r_q.st == ST_FETCH);

    always_comb begin
        case (csr_addr)
            REG_CTRL: csr_rdata = {29'd0, st_done, st_wait, st_active};
            REG_BLK:  csr_rdata = r_q.blk;
            REG_LEN:  csr_rdata = r_q.len;
            default:  csr_rdata = '0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = r_q.data;

        if (csr_we && (csr_addr == REG_BLK)) r_d.head = csr_wdata;
        if (ctrl_wr && csr_wdata[1] && st_active) r_d.abort_p = 1'b1;

        case (r_q.st)
            ST_IDLE: begin
                if (ctrl_wr && csr_wdata[0]) begin
                    r_d.blk     = r_q.head & BLK_MASK;
                    r_d.widx    = '0;
                    r_d.done    = 1'b0;
                    r_d.abort_p = 1'b0;
                    r_d.st      = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = r_q.blk | {27'd0, r_q.widx, 2'b00};
                if (mem_ack) begin
                    case (r_q.widx)
                        3'd0: begin
                            r_d.dst_inc = mem_rdata[FLG_DST_INC];
                            r_d.paced   = mem_rdata[FLG_PACED];
                            r_d.src_inc = mem_rdata[FLG_SRC_INC];
                            r_d.sel     = mem_rdata[FLG_SEL_LSB +: SEL_W];
                        end
                        3'd1:    r_d.src  = mem_rdata;
                        3'd2:    r_d.dst  = mem_rdata;
                        3'd3:    r_d.len  = mem_rdata;
                        3'd5:    r_d.link = mem_rdata;
                        default: ;
                    endcase
                    if (r_q.widx == 3'(LINK_WORD)) begin
                        r_d.st = (r_q.len[WORD_W-1:2] == '0) ? ST_LINK : ST_GATE;
                    end else begin
                        r_d.widx = r_q.widx + 3'd1;
                    end
                end
            end
            ST_GATE: begin
                if (r_q.abort_p) begin
                    r_d.abort_p = 1'b0;
                    r_d.st      = ST_IDLE;
                end else if (!r_q.paced || req_hit) begin
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.src;
                if (mem_ack) begin
                    r_d.data = mem_rdata;
                    r_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.dst;
                if (mem_ack) begin
                    r_d.src = src_nx;
                    r_d.dst = dst_nx;
                    r_d.len = r_q.len - WORD_W'(WORD_BYTES);
                    r_d.st  = (r_q.len[WORD_W-1:2] == 30'd1) ? ST_LINK : ST_GATE;
                end
            end
            ST_LINK: begin
                if (r_q.abort_p) begin
                    r_d.abort_p = 1'b0;
                    r_d.st      = ST_IDLE;
                end else if (r_q.link == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.blk  = r_q.link & BLK_MASK;
                    r_d.widx = '0;
                    r_d.st   = ST_FETCH;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dmac_chain_checker.sv
module dmac_chain_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        active,
    input logic        waiting,
    input logic        done,
    input logic        fetching,
    input logic [2:0]  fetch_idx
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req); // R1

    AST_PACE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !mem_req); // R7

    AST_BLK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        fetching && mem_req |-> !mem_we && (mem_addr[4:0] == {fetch_idx, 2'b00})); // R2

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !active && !mem_req); // R5
endmodule

bind dmac_chain_engine dmac_chain_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .active    (st_active),
    .waiting   (st_wait),
    .done      (st_done),
    .fetching  (is_fetch),
    .fetch_idx (r_q.widx)
);

// File: tb/dmac_chain_engine_tb_top.sv
module dmac_chain_engine_tb_top;
    localparam int NREQ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic [NREQ-1:0] dreq = '0;

    logic [31:0] mem [256];
    logic [31:0] wlog [64];
    int          wcount = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    dmac_chain_engine #(.NREQ(NREQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dreq(dreq)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack && rst_n;
        if (mem_req && mem_we && mem_ack) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            if (wcount < 64) wlog[wcount] <= mem_addr;
            wcount <= wcount + 1;
        end
    end

    // rows: {src_inc, dst_inc, byte length}
    localparam logic [9:0] VEC [5] = '{
        {1'b1, 1'b1, 8'd16},
        {1'b0, 1'b1, 8'd12},
        {1'b1, 1'b0, 8'd12},
        {1'b0, 1'b0, 8'd4},
        {1'b1, 1'b1, 8'd4}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic put_blk(input int idx, input logic [31:0] flg, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] n, input logic [31:0] lk);
        mem[idx] = flg;   mem[idx+1] = s; mem[idx+2] = d; mem[idx+3] = n;
        mem[idx+4] = '0;  mem[idx+5] = lk; mem[idx+6] = '0; mem[idx+7] = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        st = 32'd1;
        for (int i = 0; i < 3000 && st[0]; i++) reg_rd(2'd0, st);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] st, v;
        int base, n;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) mem[64+i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(2'd0, st);
        check(st, 32'd0, "R1 status after reset");
        check({31'd0, mem_req}, 32'd0, "R1 no request after reset");

        // table of single-descriptor copies: R3 R4 R5
        for (int r = 0; r < 5; r++) begin
            logic si, di;
            si = VEC[r][9]; di = VEC[r][8]; n = int'(VEC[r][7:0]) / 4;
            for (int i = 0; i < 16; i++) mem[128+i] = '0;
            put_blk(0, (32'(si) << 8) | (32'(di) << 4), 32'h100, 32'h200, 32'(VEC[r][7:0]), 32'h0);
            base = wcount;
            reg_wr(2'd1, 32'h0);
            reg_wr(2'd0, 32'h1);
            wait_idle();
            check(32'(wcount - base), 32'(n), "R4 word count");
            if (di) begin
                for (int i = 0; i < n; i++)
                    check(mem[128+i], si ? mem[64+i] : mem[64], "R3 dst increment data");
            end else begin
                check(mem[128], si ? mem[64+n-1] : mem[64], "R3 fixed dst data");
                check(mem[129], 32'h0, "R3 fixed dst untouched");
            end
            reg_rd(2'd0, st);
            check(st, 32'h4, "R5 end-of-chain status");
        end

        // R2 alignment of start address and first fetch address
        put_blk(16, 32'h100, 32'h104, 32'h240, 32'd4, 32'h0);
        reg_wr(2'd1, 32'h05C);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = 32'h1;
        @(negedge clk);
        csr_we = 1'b0;
        check(mem_addr, 32'h040, "R2 first fetch address");
        wait_idle();
        check(mem[144], mem[65], "R2 aligned block used");

        // R5 chain through link with low bits set, R3 both increments
        put_blk(0, 32'h0, 32'h108, 32'h248, 32'd4, 32'h07F);
        put_blk(24, 32'h110, 32'h10C, 32'h250, 32'd8, 32'h0);
        base = wcount;
        reg_wr(2'd1, 32'h0);
        reg_wr(2'd0, 32'h1);
        wait_idle();
        check(mem[146], mem[66], "R5 first block copy");
        check(mem[148], mem[67], "R5 linked block word 0");
        check(mem[149], mem[68], "R5 linked block word 1");
        check(32'(wcount - base), 32'd3, "R5 total writes");

        // R11 zero-length block passes to link
        put_blk(0, 32'h0, 32'h100, 32'h258, 32'd0, 32'h060);
        put_blk(24, 32'h0, 32'h110, 32'h260, 32'd4, 32'h0);
        base = wcount;
        reg_wr(2'd0, 32'h1);
        wait_idle();
        check(32'(wcount - base), 32'd1, "R11 single write");
        check(wlog[base], 32'h260, "R11 write goes to linked block");

        // ring, paced on request line 3: R7 R10 R6 R8
        put_blk(32, 32'h0003_0050, 32'h100, 32'h280, 32'd8, 32'h0A0);
        put_blk(40, 32'h0003_0050, 32'h100, 32'h2C0, 32'd8, 32'h080);
        base = wcount;
        reg_wr(2'd1, 32'h080);
        reg_wr(2'd0, 32'h1);
        repeat (40) @(negedge clk);
        reg_rd(2'd0, st);
        check(st, 32'h3, "R7 waiting status");
        check(32'(wcount - base), 32'd0, "R7 no write without request");
        reg_rd(2'd1, v);
        check(v, 32'h080, "R10 current block address");
        reg_rd(2'd2, v);
        check(v, 32'd8, "R10 remaining length");
        dreq[5] = 1'b1;
        repeat (20) @(negedge clk);
        check(32'(wcount - base), 32'd0, "R7 other request line ignored");
        dreq[3] = 1'b1;
        for (int i = 0; i < 2000 && (wcount - base) < 5; i++) @(negedge clk);
        dreq[3] = 1'b0;
        check(wlog[base],   32'h280, "R6 ring pass 1 word 0");
        check(wlog[base+1], 32'h284, "R3 ring dst advance");
        check(wlog[base+2], 32'h2C0, "R6 second block start");
        check(wlog[base+4], 32'h280, "R6 restart on revisit");
        reg_wr(2'd0, 32'h2);
        repeat (5) @(negedge clk);
        reg_rd(2'd0, st);
        check(st, 32'h0, "R8 idle after abort");
        n = wcount;
        dreq[3] = 1'b1;
        repeat (30) @(negedge clk);
        check(32'(wcount - n), 32'd0, "R8 no writes after abort");
        dreq = '0;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule